// File: doc/BRIEF.md
# Program RAM Bootstrap Loader

After reset this block fills a 512-word, 24-bit program RAM and then hands control to the processor. It first reads one word from the external bus at the boot base address, $C000. Bit 23 of that word is a strap that picks one of two fill paths.

When the strap is one, the loader reads consecutive bytes from a byte-wide memory-mapped ROM through a request/acknowledge read port. The reads start at the base address. Each RAM word is packed from three bytes. When the strap is zero, the loader enables the host interface and takes whole words from a host receive register that has a data-available flag. On this path a host flag can end the download before all 512 words have arrived.

In both cases the words are written from RAM address 0 upward. When loading ends, the loader gives a one-cycle start pulse and presents operating mode 2 in the same cycle. Execution then begins at program address 0.

Top module: `pram_boot_seq`

## Requirements
- R1: After reset the first external read uses address $C000. When `ext_ack` arrives, bit 23 of `ext_rdata` selects the path: 1 selects the byte path and 0 selects the host path.
- R2: On the byte path, word i is built from the bytes at $C000+3i, $C000+3i+1 and $C000+3i+2. Each byte is taken from `ext_rdata[7:0]`. The first byte fills bits 7:0, the second fills bits 15:8 and the third fills bits 23:16. Words are written in a single cycle each, to RAM addresses 0, 1, 2 and so on in order.
- R3: While `ext_req` is high and `ext_ack` is low, the request stays high in the next cycle and `ext_addr` does not change, for any number of wait cycles.
- R4: On the host path `host_en` is high while the loader waits for words. `host_pop` is asserted only when `host_valid` is high, and each pop takes one word. That word is written to RAM, unchanged, in the next cycle, at the next address.
- R5: On the host path, while the loader waits for a word, `host_flag0` high ends the load. It takes priority over `host_valid`, so the number of words written can be anything from 0 to 511.
- R6: At most 512 words are written. The load ends right after the write to address 511.
- R7: When loading ends, `start` pulses high for exactly one cycle. In that same cycle `op_mode` becomes 2 and `busy` falls. Afterwards `op_mode` stays 2, `busy` stays low and `start` does not pulse again.
- R8: A synchronous reset, even in the middle of a load, returns the loader to the strap read. During reset and in the cycle after it, there is no RAM write and no start pulse, `host_en` is low and `op_mode` is 0. The next load begins again at RAM address 0.
- R9: The two paths are exclusive. On the host path `ext_req` stays low after the strap read. On the byte path `host_en` and `host_pop` never assert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_req | output | 1 | External read request |
| ext_addr | output | 16 | External read address, held until acknowledged |
| ext_ack | input | 1 | Read acknowledge; `ext_rdata` is valid in this cycle |
| ext_rdata | input | 24 | External read data (bit 23 is the strap, bits 7:0 are a byte) |
| host_en | output | 1 | Enables the host interface logic |
| host_valid | input | 1 | Host receive register holds a word |
| host_data | input | 24 | Host receive register contents |
| host_flag0 | input | 1 | Host request to end the download |
| host_pop | output | 1 | Takes the word from the host receive register |
| ram_we | output | 1 | Program RAM write enable |
| ram_addr | output | 9 | Program RAM write address |
| ram_wdata | output | 24 | Program RAM write data |
| busy | output | 1 | High while loading |
| start | output | 1 | One-cycle pulse when execution starts |
| op_mode | output | 2 | Operating mode: 0 while loading, 2 after |

## Verification
The assertions assume that `ext_ack` comes only while `ext_req` is high and lasts one cycle per read. They also assume that `host_data` is stable whenever `host_valid` is high, and that reset is held for at least one clock edge. The bench's read responder raises `ext_ack` only for a pending request, lowers it in the cycle after it is used, and inserts a programmable number of wait cycles. The host model changes its data only after a pop, and can hold `host_valid` low for a gap before offering the next word. Reset is always held across several edges, including the reset applied in the middle of a load.

// File: rtl/pbl_pkg.sv
package pbl_pkg;

    typedef enum logic [2:0] {
        ST_STRAP = 3'd0,
        ST_BYTE  = 3'd1,
        ST_BWR   = 3'd2,
        ST_HEN   = 3'd3,
        ST_HWAIT = 3'd4,
        ST_HWR   = 3'd5,
        ST_FIN   = 3'd6,
        ST_RUN   = 3'd7
    } boot_st_e;

    localparam logic [1:0] MODE_LOAD = 2'd0;
    localparam logic [1:0] MODE_EXEC = 2'd2;

    function automatic logic st_loading(boot_st_e s);
        return !(s == ST_FIN || s == ST_RUN);
    endfunction

    function automatic logic st_writes(boot_st_e s);
        return (s == ST_BWR) || (s == ST_HWR);
    endfunction

    function automatic logic st_host(boot_st_e s);
        return (s == ST_HEN) || (s == ST_HWAIT) || (s == ST_HWR);
    endfunction

endpackage

// File: rtl/pbl_word_ctr.sv
module pbl_word_ctr #(
    parameter int WORDS = 512,
    localparam int IW = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [IW-1:0] idx,
    output logic          at_last
);
    localparam logic [IW-1:0] LAST = IW'(WORDS - 1);

    always_ff @(posedge clk) begin
        if (rst)       idx <= '0;
        else if (step) idx <= idx + 1'b1;
    end

    assign at_last = (idx == LAST);
endmodule

// File: rtl/pbl_byte_pack.sv
module pbl_byte_pack #(
    parameter int WORD_W = 24,
    localparam int LANES = WORD_W / 8,
    localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [7:0]        byte_in,
    output logic [WORD_W-1:0] word,
    output logic              full
);
    localparam logic [LW-1:0] LAST_LANE = LW'(LANES - 1);

    logic [LW-1:0] lane;

    always_ff @(posedge clk) begin
        if (rst)
            lane <= '0;
        else if (take)
            lane <= (lane == LAST_LANE) ? '0 : lane + 1'b1;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                word[g*8 +: 8] <= '0;
            else if (take && lane == LW'(g))
                word[g*8 +: 8] <= byte_in;
        end
    end

    assign full = take && (lane == LAST_LANE);
endmodule

// File: rtl/pbl_rd_ptr.sv
module pbl_rd_ptr #(
    parameter int              AW   = 16,
    parameter logic [AW-1:0]   BASE = 16'hC000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [AW-1:0] addr
);
    always_ff @(posedge clk) begin
        if (rst)       addr <= BASE;
        else if (step) addr <= addr + 1'b1;
    end
endmodule

// File: rtl/pram_boot_seq.sv
module pram_boot_seq
    import pbl_pkg::*;
#(
    parameter int              WORDS     = 512,
    parameter int              WORD_W    = 24,
    parameter int              EXT_AW    = 16,
    parameter logic [EXT_AW-1:0] BOOT_BASE = 16'hC000,
    parameter int              STRAP_BIT = 23,
    localparam int             IW        = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    output logic              ext_req,
    output logic [EXT_AW-1:0] ext_addr,
    input  logic              ext_ack,
    input  logic [WORD_W-1:0] ext_rdata,
    output logic              host_en,
    input  logic              host_valid,
    input  logic [WORD_W-1:0] host_data,
    input  logic              host_flag0,
    output logic              host_pop,
    output logic              ram_we,
    output logic [IW-1:0]     ram_addr,
    output logic [WORD_W-1:0] ram_wdata,
    output logic              busy,
    output logic              start,
    output logic [1:0]        op_mode
);
    boot_st_e          st, st_nx;
    logic              byte_take, pack_full, at_last;
    logic [WORD_W-1:0] pack_word, host_hold;
    logic              unused_rdata;

    assign unused_rdata = ^ext_rdata;

    assign byte_take = (st == ST_BYTE) && ext_ack;
    assign host_pop  = (st == ST_HWAIT) && !host_flag0 && host_valid;

    pbl_rd_ptr #(.AW(EXT_AW), .BASE(BOOT_BASE)) i_ptr (
        .clk (clk), .rst (rst), .step (byte_take), .addr (ext_addr)
    );

    pbl_byte_pack #(.WORD_W(WORD_W)) i_pack (
        .clk (clk), .rst (rst), .take (byte_take),
        .byte_in (ext_rdata[7:0]), .word (pack_word), .full (pack_full)
    );

    pbl_word_ctr #(.WORDS(WORDS)) i_ctr (
        .clk (clk), .rst (rst), .step (ram_we),
        .idx (ram_addr), .at_last (at_last)
    );

    always_ff @(posedge clk) begin
        if (rst)           host_hold <= '0;
        else if (host_pop) host_hold <= host_data;
    end

    always_comb begin
        st_nx = st;
        case (st)
            ST_STRAP: if (ext_ack) st_nx = ext_rdata[STRAP_BIT] ? ST_BYTE : ST_HEN;
            ST_BYTE:  if (pack_full) st_nx = ST_BWR;
            ST_BWR:   st_nx = at_last ? ST_FIN : ST_BYTE;
            ST_HEN:   st_nx = ST_HWAIT;
            ST_HWAIT: begin
                if (host_flag0)      st_nx = ST_FIN;
                else if (host_valid) st_nx = ST_HWR;
            end
            ST_HWR:   st_nx = at_last ? ST_FIN : ST_HWAIT;
            ST_FIN:   st_nx = ST_RUN;
            default:  st_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_STRAP;
        else     st <= st_nx;
    end

    assign ext_req   = (st == ST_STRAP) || (st == ST_BYTE);
    assign host_en   = st_host(st);
    assign ram_we    = st_writes(st);
    assign ram_wdata = (st == ST_BWR) ? pack_word : host_hold;
    assign busy      = st_loading(st);
    assign start     = (st == ST_FIN);
    assign op_mode   = st_loading(st) ? MODE_LOAD : MODE_EXEC;
endmodule

// File: rtl/pbl_checker.sv
module pbl_checker #(
    parameter int EXT_AW = 16,
    parameter int WORD_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              ext_req,
    input logic [EXT_AW-1:0] ext_addr,
    input logic              ext_ack,
    input logic              host_en,
    input logic              host_valid,
    input logic [WORD_W-1:0] host_data,
    input logic              host_pop,
    input logic              ram_we,
    input logic [WORD_W-1:0] ram_wdata,
    input logic              busy,
    input logic              start,
    input logic [1:0]        op_mode
);
    a_r3_hold_request: assert property (@(posedge clk) disable iff (rst)
        ext_req && !ext_ack |=> ext_req && $stable(ext_addr));

    a_r4_pop_needs_valid: assert property (@(posedge clk) disable iff (rst)
        host_pop |-> host_valid && host_en);

    a_r4_write_after_pop: assert property (@(posedge clk) disable iff (rst)
        host_pop |=> ram_we && ram_wdata == $past(host_data));

    a_r2_single_write: assert property (@(posedge clk) disable iff (rst)
        ram_we |=> !ram_we);

    a_r7_start_mode: assert property (@(posedge clk) disable iff (rst)
        start |-> op_mode == 2'd2 && !busy);

    a_r7_start_once: assert property (@(posedge clk) disable iff (rst)
        start |=> !start && op_mode == 2'd2 && !busy);

    a_r9_paths_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(ext_req && host_en));

    a_r8_reset_idle: assert property (@(posedge clk)
        rst |=> !ram_we && !start && !host_en && op_mode == 2'd0);
endmodule

bind pram_boot_seq pbl_checker #(.EXT_AW(EXT_AW), .WORD_W(WORD_W)) i_pbl_checker (.*);

// File: tb/test_pram_boot_seq.sv
`timescale 1ns/1ps
module test_pram_boot_seq;
    localparam int WORDS = 512;
    localparam int BASE  = 'hC000;
    localparam int NCASE = 6;
    // fields: strap, wait cycles, host gap, flag after N words, abort after N writes
    localparam int CASES [NCASE][5] = '{
        '{1, 0, 0, 0,    0},
        '{1, 2, 0, 0,    0},
        '{0, 0, 0, 9999, 0},
        '{0, 0, 2, 100,  0},
        '{0, 0, 0, 0,    0},
        '{0, 0, 1, 511,  0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_req, ext_ack = 1'b0;
    logic [15:0] ext_addr;
    logic [23:0] ext_rdata = '0;
    logic        host_en, host_valid = 1'b0, host_flag0 = 1'b0, host_pop;
    logic [23:0] host_data = '0;
    logic        ram_we, busy, start;
    logic [8:0]  ram_addr;
    logic [23:0] ram_wdata;
    logic [1:0]  op_mode;

    always #2 clk = ~clk;

    pram_boot_seq i_pram_boot_seq (.*);

    int checks = 0, fails = 0, cyc = 0;
    int c_strap = 0, c_wait = 0, c_gap = 0, c_flag = 0;
    int wc = 0, exp_ext = BASE, strap_done = 0;
    int hidx = 0, stall = 0;
    int wr_n = 0, start_seen = 0, r9_bad = 0, data_bad = 0;
    logic pop_q = 1'b0;

    function automatic logic [7:0] bval(int a);
        return 8'(a * 37 + (a >>> 8) * 11 + 5);
    endfunction

    function automatic logic [23:0] hword(int i);
        return 24'(i * 70001) ^ 24'h5A3C96;
    endfunction

    function automatic logic [23:0] bword(int i);
        int a = BASE + 3 * i;
        return {bval(a + 2), bval(a + 1), bval(a)};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // external read responder
    always @(negedge clk) begin
        if (rst) begin
            ext_ack = 1'b0; wc = 0; exp_ext = BASE; strap_done = 0;
        end else if (ext_ack) begin
            ext_ack = 1'b0; wc = 0;
        end else if (ext_req) begin
            if (wc >= c_wait) begin
                check(int'(ext_addr) == exp_ext, strap_done ? "R2 byte address" : "R1 strap address",
                      int'(ext_addr), exp_ext);
                ext_rdata = {c_strap[0], 15'h0, bval(int'(ext_addr))};
                ext_ack = 1'b1;
                if (strap_done != 0) exp_ext++;
                strap_done = 1;
            end else begin
                wc++;
            end
        end
    end

    // host receive register model
    always @(posedge clk) pop_q <= host_pop;
    always @(negedge clk) begin
        if (rst) begin
            hidx = 0; stall = c_gap;
        end else if (pop_q) begin
            hidx++; stall = c_gap;
        end else if (stall > 0) begin
            stall--;
        end
        host_valid = (stall == 0);
        host_data  = hword(hidx);
        host_flag0 = (hidx >= c_flag);
    end

    // write and completion monitor
    always @(negedge clk) begin
        if (rst) begin
            wr_n = 0; start_seen = 0;
        end else begin
            if (ram_we) begin
                if (int'(ram_addr) != wr_n || ram_wdata != (c_strap != 0 ? bword(wr_n) : hword(wr_n))) begin
                    data_bad++;
                    check(0, c_strap != 0 ? "R2 byte word" : "R4 host word",
                          int'(ram_wdata), c_strap != 0 ? int'(bword(wr_n)) : int'(hword(wr_n)));
                end
                wr_n++;
            end
            if (start) begin
                start_seen++;
                check(op_mode == 2'd2 && !busy, "R7 mode with start", int'(op_mode), 2);
            end
            if (c_strap != 0 && (host_en || host_pop)) r9_bad++;
            if (c_strap == 0 && strap_done != 0 && !ext_ack && ext_req) r9_bad++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic run_case(input int strap, input int waitn, input int gap, input int flag, input int abort_at);
        int expw, n;
        c_strap = strap; c_wait = waitn; c_gap = gap; c_flag = flag;
        r9_bad = 0; data_bad = 0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(!ram_we && !start && !host_en && op_mode == 2'd0, "R8 reset outputs",
              {ram_we, start, host_en, op_mode}, 0);
        rst = 1'b0;
        expw = (strap != 0) ? WORDS : ((flag < WORDS) ? flag : WORDS);
        if (abort_at > 0) begin
            n = 0;
            while (wr_n < abort_at && n < 20000) begin @(posedge clk); #1; n++; end
            rst = 1'b1;
            repeat (2) @(negedge clk);
            check(!ram_we && !start && op_mode == 2'd0 && !host_en, "R8 mid-load reset idle",
                  {ram_we, start, host_en, op_mode}, 0);
            rst = 1'b0;
        end
        n = 0;
        while (start_seen == 0 && n < 20000) begin @(posedge clk); #1; n++; end
        check(start_seen == 1, "R7 start pulse seen", start_seen, 1);
        check(wr_n == expw, (expw < WORDS) ? "R5 early end word count" : "R6 full word count", wr_n, expw);
        check(data_bad == 0, (strap != 0) ? "R2 byte path data" : "R4 host path data", data_bad, 0);
        repeat (6) @(negedge clk);
        check(start_seen == 1 && op_mode == 2'd2 && !busy && !ram_we, "R7 held after start",
              {start_seen[3:0], op_mode, busy, ram_we}, 8'h18);
        check(r9_bad == 0, "R9 path exclusive", r9_bad, 0);
    endtask

    initial begin
        for (int k = 0; k < NCASE; k++)
            run_case(CASES[k][0], CASES[k][1], CASES[k][2], CASES[k][3], CASES[k][4]);
        // R8: reset during a byte load restarts from address 0
        run_case(1, 1, 0, 0, 37);
        // R8: reset during a host load restarts from address 0
        run_case(0, 0, 1, 9999, 20);
        // R1/R5: host path with flag raised after a single word
        run_case(0, 3, 0, 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule